// File: doc/BRIEF.md
# Event-Driven Leaky Integrate-and-Fire Neuron

This block is one neuron of a synaptic array. It keeps a signed membrane potential and adds a weight to it each time an input event arrives. Each event carries a 2-bit axon class, and the class selects one of three programmable synaptic weights. Events may arrive in any order during the input phase of a time step. The potential may go negative during that phase.

A one-cycle time-step strobe closes the step. On the strobe the neuron first compares the accumulated potential with its threshold. If the potential is strictly greater, the neuron fires and the potential goes to zero. The leak is then added, and a negative result is clipped to zero. The spike appears as a one-cycle pulse in the cycle after the strobe.

The three weights, the leak and the threshold are loaded through a small write port. The current potential is visible on an output, so a surrounding array can observe and trace it.

Top module: `lif_neuron_unit`

## Requirements
- R1: After reset the potential is 0, spike and collision outputs are 0, all weights and the leak are 0, and the threshold is 1.
- R2: A configuration write (cfg_we high) with select 0, 1 or 2 loads the weight for axon class 0, 1 or 2. Select 3 loads the leak and select 4 loads the threshold. Weights and leak are 9-bit two's complement (-256..255). Selects 5 to 7 change nothing. A written value is used by events from the next cycle on.
- R3: A threshold write treats the 9-bit data as unsigned. A value of 0 is stored as 1, and any value above 256 is stored as 256.
- R4: An input event (ev_valid high, sync low) of class 0, 1 or 2 adds that class's weight to the potential, visible on `vmem` one cycle later. Class 3 leaves the potential unchanged. With neither event nor strobe, the potential holds.
- R5: Accumulation saturates at 131071 and at -131072 and never wraps.
- R6: On a strobe, if the potential is strictly greater than the threshold, `spike` is 1 in the next cycle and the potential is set to 0 before the leak is applied. Otherwise `spike` is 0 in that cycle.
- R7: The leak is added after the threshold check. A negative result is clipped to 0, so the potential is never negative after a strobe. Negative values are allowed between strobes.
- R8: Without saturation, the spike decision and the potential after a strobe do not depend on the order of the events in the step.
- R9: If an event and a strobe arrive in the same cycle, the strobe is processed, the event is dropped, and `collide_err` is 1 for the next cycle only.
- R10: `spike` is high only in the cycle after a strobe. Back-to-back strobes are each evaluated on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target: 0..2 weights, 3 leak, 4 threshold |
| cfg_data | input | 9 | Configuration value |
| ev_valid | input | 1 | Synaptic input event |
| ev_type | input | 2 | Axon class of the event (0..2; 3 ignored) |
| sync_strobe | input | 1 | Time-step end strobe |
| spike | output | 1 | One-cycle fire pulse |
| collide_err | output | 1 | Event dropped because a strobe arrived in the same cycle |
| vmem | output | 18 | Current membrane potential, two's complement |

## Verification
The embedded assertions check several rules on every clock. A spike pulse must be preceded by a strobe. The potential after a strobe must be non-negative, and after a spike it can be no larger than the largest leak. Idle cycles must leave the potential unchanged. A collision must raise the error flag. The stored threshold must stay within 1..256, and writes to unused selects must leave the configuration unchanged.

Only the bench scenarios can show the following, by comparing the unit against a behavioural reference on every clock:
- the strict threshold boundary at 1 and 256, including the write clamping;
- the saturation values after long runs of events;
- negative potentials before the strobe, and their clipping at the strobe;
- identical results for reordered event sequences.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int LIF_VMEM_W  = 18;
  localparam int LIF_PARAM_W = 9;
  localparam int LIF_NTYPES  = 3;

  typedef enum logic [2:0] {
    SEL_W0   = 3'd0,
    SEL_W1   = 3'd1,
    SEL_W2   = 3'd2,
    SEL_LEAK = 3'd3,
    SEL_THR  = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs
  import lif_pkg::*;
#(
  parameter int PW     = LIF_PARAM_W,
  parameter int NTYPES = LIF_NTYPES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [2:0]             sel,
  input  logic [PW-1:0]          data,
  output logic [NTYPES*PW-1:0]   weights,
  output logic [PW-1:0]          leak,
  output logic [PW-1:0]          thr
);
  localparam logic [PW-1:0] THR_MAX = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] THR_MIN = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] leak_q, leak_d, thr_q, thr_d;
  logic          leak_en, thr_en;

  genvar g;
  generate
    for (g = 0; g < NTYPES; g++) begin : g_weight
      logic [PW-1:0] w_q;
      logic          w_en;
      always_comb w_en = we && (sel == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= data;
      end
      assign weights[g*PW +: PW] = w_q;
    end
  endgenerate

  always_comb begin
    leak_en = we && (sel == SEL_LEAK);
    thr_en  = we && (sel == SEL_THR);
    leak_d  = data;
    if (data == '0)          thr_d = THR_MIN;
    else if (data > THR_MAX) thr_d = THR_MAX;
    else                     thr_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leak_q <= '0;
      thr_q  <= THR_MIN;
    end else begin
      if (leak_en) leak_q <= leak_d;
      if (thr_en)  thr_q  <= thr_d;
    end
  end

  assign leak = leak_q;
  assign thr  = thr_q;

  assert_thr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != '0) && (thr_q <= THR_MAX));

  assert_unused_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (sel > SEL_THR)) |=> ($stable(thr_q) && $stable(leak_q) && $stable(weights)));
endmodule

// File: rtl/lif_accum.sv
module lif_accum
  import lif_pkg::*;
#(
  parameter int VW     = LIF_VMEM_W,
  parameter int PW     = LIF_PARAM_W,
  parameter int NTYPES = LIF_NTYPES,
  parameter int TW     = 2
) (
  input  logic signed [VW-1:0]    vmem,
  input  logic [TW-1:0]           ev_type,
  input  logic [NTYPES*PW-1:0]    weights,
  output logic signed [VW-1:0]    vmem_acc,
  output logic                    type_ok
);
  localparam logic signed [VW:0] SUM_MAX = {2'b00, {(VW-1){1'b1}}};
  localparam logic signed [VW:0] SUM_MIN = {2'b11, {(VW-1){1'b0}}};

  logic signed [PW-1:0] w_sel;
  logic signed [VW:0]   sum;

  always_comb begin
    w_sel   = '0;
    type_ok = 1'b0;
    for (int k = 0; k < NTYPES; k++) begin
      if (ev_type == TW'(k)) begin
        w_sel   = weights[k*PW +: PW];
        type_ok = 1'b1;
      end
    end
  end

  always_comb begin
    sum = {vmem[VW-1], vmem} + {{(VW+1-PW){w_sel[PW-1]}}, w_sel};
    if (!type_ok)           vmem_acc = vmem;
    else if (sum > SUM_MAX) vmem_acc = SUM_MAX[VW-1:0];
    else if (sum < SUM_MIN) vmem_acc = SUM_MIN[VW-1:0];
    else                    vmem_acc = sum[VW-1:0];
  end
endmodule

// File: rtl/lif_sync_eval.sv
module lif_sync_eval
  import lif_pkg::*;
#(
  parameter int VW = LIF_VMEM_W,
  parameter int PW = LIF_PARAM_W
) (
  input  logic signed [VW-1:0] vmem,
  input  logic [PW-1:0]        leak,
  input  logic [PW-1:0]        thr,
  output logic                 fire,
  output logic signed [VW-1:0] vmem_next
);
  localparam logic signed [VW:0] SUM_MAX = {2'b00, {(VW-1){1'b1}}};

  logic signed [VW-1:0] thr_ext, base;
  logic signed [VW:0]   lsum;

  always_comb begin
    thr_ext = {{(VW-PW){1'b0}}, thr};
    fire    = vmem > thr_ext;
    base    = fire ? '0 : vmem;
    lsum    = {base[VW-1], base} + {{(VW+1-PW){leak[PW-1]}}, leak};
    if (lsum[VW])            vmem_next = '0;
    else if (lsum > SUM_MAX) vmem_next = SUM_MAX[VW-1:0];
    else                     vmem_next = lsum[VW-1:0];
  end
endmodule

// File: rtl/lif_neuron_unit.sv
module lif_neuron_unit
  import lif_pkg::*;
#(
  parameter int VW     = LIF_VMEM_W,
  parameter int PW     = LIF_PARAM_W,
  parameter int NTYPES = LIF_NTYPES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [PW-1:0] cfg_data,
  input  logic          ev_valid,
  input  logic [1:0]    ev_type,
  input  logic          sync_strobe,
  output logic          spike,
  output logic          collide_err,
  output logic [VW-1:0] vmem
);
  localparam int TW = 2;
  localparam logic signed [VW-1:0] LEAK_MAX = {{(VW-PW+1){1'b0}}, {(PW-1){1'b1}}};

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NTYPES*PW-1:0] weights;
  logic [PW-1:0]        leak, thr;

  lif_cfg_regs #(.PW(PW), .NTYPES(NTYPES)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .weights(weights), .leak(leak), .thr(thr)
  );

  logic signed [VW-1:0] vmem_q, vmem_d, vmem_acc, vmem_sync;
  logic                 type_ok, fire;

  lif_accum #(.VW(VW), .PW(PW), .NTYPES(NTYPES), .TW(TW)) u_acc (
    .vmem(vmem_q), .ev_type(ev_type), .weights(weights),
    .vmem_acc(vmem_acc), .type_ok(type_ok)
  );

  lif_sync_eval #(.VW(VW), .PW(PW)) u_sync (
    .vmem(vmem_q), .leak(leak), .thr(thr), .fire(fire), .vmem_next(vmem_sync)
  );

  logic vmem_en, spike_q, spike_d, err_q, err_d;

  always_comb begin
    vmem_en = sync_strobe || (ev_valid && type_ok);
    vmem_d  = vmem_q;
    if (sync_strobe)   vmem_d = vmem_sync;
    else if (ev_valid) vmem_d = vmem_acc;
    spike_d = sync_strobe && fire;
    err_d   = sync_strobe && ev_valid;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      vmem_q  <= '0;
      spike_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (vmem_en) vmem_q <= vmem_d;
      spike_q <= spike_d;
      err_q   <= err_d;
    end
  end

  assign vmem        = vmem_q;
  assign spike       = spike_q;
  assign collide_err = err_q;

  assert_spike_after_sync_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    spike_q |-> $past(sync_strobe));

  assert_nonneg_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    sync_strobe |=> !vmem_q[VW-1]);

  assert_spike_resets_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    spike_q |-> (vmem_q <= LEAK_MAX));

  assert_collision_flag_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (sync_strobe && ev_valid) |=> collide_err);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (!sync_strobe && !ev_valid) |=> $stable(vmem_q));
endmodule

// File: tb/lif_neuron_unit_bench.sv
`timescale 1ns/1ps
module lif_neuron_unit_bench;
  localparam int VMAX = 131071;
  localparam int VMIN = -131072;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [8:0] cfg_data = '0;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_type = '0;
  logic       sync_strobe = 1'b0;
  logic       spike, collide_err;
  logic [17:0] vmem;

  always #2 clk = ~clk;

  lif_neuron_unit u_lif_neuron_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .ev_valid(ev_valid), .ev_type(ev_type), .sync_strobe(sync_strobe),
    .spike(spike), .collide_err(collide_err), .vmem(vmem)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit chk_en = 0;

  int mv = 0, ml = 0, mt = 1;
  int mw[3] = '{0, 0, 0};
  int msp = 0, merr = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(int v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  // Behavioural reference, updated with the same inputs the unit sees
  always @(posedge clk) begin
    if (!rst_n) begin
      mv = 0; ml = 0; mt = 1; mw = '{0, 0, 0}; msp = 0; merr = 0;
    end else begin
      msp = 0;
      merr = (sync_strobe && ev_valid) ? 1 : 0;
      if (sync_strobe) begin
        int b;
        b = mv;
        if (mv > mt) begin msp = 1; b = 0; end
        b = b + ml;
        if (b < 0) b = 0;
        mv = sat(b);
      end else if (ev_valid && ev_type != 2'd3) begin
        mv = sat(mv + mw[ev_type]);
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0, 3'd1, 3'd2: mw[cfg_sel] = int'($signed(cfg_data));
          3'd3: ml = int'($signed(cfg_data));
          3'd4: mt = (cfg_data == 0) ? 1 : ((cfg_data > 256) ? 256 : int'(cfg_data));
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check({cur_req, " vmem"}, int'($signed(vmem)), mv);
      check({cur_req, " spike"}, int'(spike), msp);
      check({cur_req, " collide_err"}, int'(collide_err), merr);
    end
  end

  task automatic wr(logic [2:0] s, logic [8:0] d);
    cfg_we = 1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ev(logic [1:0] t);
    ev_valid = 1; ev_type = t;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic sy();
    sync_strobe = 1;
    @(negedge clk);
    sync_strobe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 vmem", int'($signed(vmem)), 0);
    check("R1 spike", int'(spike), 0);
    check("R1 collide_err", int'(collide_err), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_en = 1;

    // R1: default threshold 1, zero weights
    cur_req = "R1";
    ev(2'd0);
    check("R1 zero weight", int'($signed(vmem)), 0);

    // R2 configuration and R4 accumulation
    cur_req = "R2";
    wr(3'd0, 9'd10); wr(3'd1, 9'h1EC); wr(3'd2, 9'd100);
    wr(3'd5, 9'd77); wr(3'd7, 9'd1);
    wr(3'd3, 9'h1FD); wr(3'd4, 9'd50);
    cur_req = "R4";
    ev(2'd0); ev(2'd0); ev(2'd0);
    check("R2 weight class 0", int'($signed(vmem)), 30);
    ev(2'd1); ev(2'd2);
    check("R4 classes 1 and 2", int'($signed(vmem)), 110);
    ev(2'd3);
    check("R4 class 3 ignored", int'($signed(vmem)), 110);
    repeat (2) @(negedge clk);
    check("R4 idle hold", int'($signed(vmem)), 110);

    // R6 fire and reset before leak
    cur_req = "R6";
    sy();
    check("R6 spike", int'(spike), 1);
    check("R6 reset then leak clipped", int'($signed(vmem)), 0);
    @(negedge clk);
    check("R10 pulse one cycle", int'(spike), 0);

    // R7 leak after check
    cur_req = "R7";
    ev(2'd0); ev(2'd0); ev(2'd0); ev(2'd0);
    sy();
    check("R7 no spike", int'(spike), 0);
    check("R7 leak applied", int'($signed(vmem)), 37);

    // R3 threshold clamp
    cur_req = "R3";
    wr(3'd3, 9'd0); wr(3'd4, 9'd0);
    sy();
    check("R3 thr 1 fires", int'(spike), 1);
    wr(3'd0, 9'd1); ev(2'd0); sy();
    check("R3 equal to 1 no spike", int'(spike), 0);
    ev(2'd0); sy();
    check("R3 above 1 spikes", int'(spike), 1);
    wr(3'd4, 9'd400); wr(3'd0, 9'd128); ev(2'd0); ev(2'd0); sy();
    check("R3 equal to 256 no spike", int'(spike), 0);
    check("R3 vmem 256", int'($signed(vmem)), 256);
    wr(3'd0, 9'd1); ev(2'd0); sy();
    check("R3 257 spikes", int'(spike), 1);

    // R8 order independence
    cur_req = "R8";
    wr(3'd4, 9'd60); wr(3'd0, 9'd30); wr(3'd1, 9'h1EC);
    ev(2'd0); ev(2'd0); ev(2'd0); ev(2'd1); sy();
    check("R8 order A spike", int'(spike), 1);
    ev(2'd1);
    check("R7 negative allowed mid-step", int'($signed(vmem)), -20);
    ev(2'd0); ev(2'd0); ev(2'd0); sy();
    check("R8 order B spike", int'(spike), 1);
    check("R8 order B vmem", int'($signed(vmem)), 0);

    // R9 collision
    cur_req = "R9";
    ev_valid = 1; ev_type = 2'd0; sync_strobe = 1;
    @(negedge clk);
    ev_valid = 0; sync_strobe = 0;
    check("R9 flag", int'(collide_err), 1);
    check("R9 event dropped", int'($signed(vmem)), 0);
    @(negedge clk);
    check("R9 flag one cycle", int'(collide_err), 0);

    // R5 saturation
    cur_req = "R5";
    wr(3'd0, 9'd255);
    for (int i = 0; i < 520; i++) ev(2'd0);
    check("R5 high saturation", int'($signed(vmem)), VMAX);
    wr(3'd1, 9'h100);
    for (int i = 0; i < 1100; i++) ev(2'd1);
    check("R5 low saturation", int'($signed(vmem)), VMIN);
    sy();
    check("R7 clip to zero", int'($signed(vmem)), 0);

    // R10 back-to-back strobes
    cur_req = "R10";
    wr(3'd3, 9'd200); wr(3'd4, 9'd100);
    sync_strobe = 1;
    @(negedge clk);
    check("R10 first strobe no spike", int'(spike), 0);
    check("R10 first strobe leak", int'($signed(vmem)), 200);
    @(negedge clk);
    sync_strobe = 0;
    check("R10 second strobe spikes", int'(spike), 1);
    check("R10 second strobe vmem", int'($signed(vmem)), 200);
    @(negedge clk);
    check("R10 no spike without strobe", int'(spike), 0);

    // R1 reset mid-run
    cur_req = "R1";
    chk_en = 0;
    rst_n = 0;
    @(negedge clk);
    check("R1 async clear", int'($signed(vmem)), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_en = 1;
    wr(3'd3, 9'd5); sy();
    check("R1 threshold back to 1", int'($signed(vmem)), 5);
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule